// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block sits on the fast side of a fractional-N synthesizer loop. It counts cycles of the input clock, which runs at the oscillator rate, and produces one single-cycle pulse per divider period for the phase comparator. Most periods last N cycles. Each period boundary adds a small fractional increment into an accumulator that wraps at a modulus of 8 or 5. When the accumulator wraps, the next period lasts N+1 cycles, so over a full accumulator cycle the average ratio is N plus the increment divided by the modulus.

The accumulator also feeds a spur-cancellation path. After every divider pulse the block opens a window of fixed length and holds a digital amplitude for that window. The amplitude is the accumulator contents multiplied by an 8-bit compensation code. A current-injection stage outside this block turns that amplitude into charge. All configuration inputs are copied into the working set only at a period boundary, so a reprogrammed ratio never cuts a period short or lengthens it part way through.

Top module: `frac_div_ctrl`

## Requirements
- R1: While `rst_n` is low or `pwr_dn` is high, the block is cleared at each clock edge: `div_pulse` and `comp_active` are 0, the accumulator and the pending stretch are zero, and the counter restarts. The first `div_pulse` then appears N cycles after the clear is released.
- R2: `div_pulse` is high for exactly one cycle per period. The distance between two pulses is N cycles, or N+1 cycles when the previous boundary produced an accumulator wrap.
- R3: At every boundary the accumulator adds the increment `nf_inc`. It wraps modulo 8 when `mod5_sel` is 0 and modulo 5 when `mod5_sel` is 1. A wrap, meaning a sum at or above the modulus, subtracts the modulus and stretches the following period to N+1.
- R4: In modulo-5 mode, an increment of 5, 6 or 7 is first reduced by 5. Its average ratio is therefore N + (nf mod 5)/5.
- R5: `n_ratio`, `nf_inc`, `mod5_sel` and `fc_code` are sampled only at the clock edge that raises `div_pulse`. A change made part way through a period affects only the period that starts after the next pulse.
- R6: When the sampled `mod5_sel` differs from the modulus in use, that boundary leaves the accumulator at zero and applies no stretch.
- R7: A `n_ratio` below 512 is treated as 512.
- R8: `comp_active` rises on the cycle after `div_pulse` and stays high for exactly 128 cycles.
- R9: During the window, `comp_level` equals the accumulator value after that boundary's update multiplied by the `fc_code` sampled at the same boundary. It is an unsigned 11-bit value, constant for the whole window, and 0 outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at the oscillator rate |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_dn | input | 1 | Synchronous power-down, clears like reset |
| n_ratio | input | 16 | Integer divide ratio N |
| nf_inc | input | 3 | Fractional increment |
| mod5_sel | input | 1 | Accumulator modulus: 0 selects 8, 1 selects 5 |
| fc_code | input | 8 | Compensation amplitude code |
| div_pulse | output | 1 | One-cycle pulse per divider period |
| comp_active | output | 1 | Compensation window |
| comp_level | output | 11 | Compensation amplitude, accumulator times code |

## Verification
A corrupted accumulator shows up at the ports in two places. The first is the length of the period that follows the bad boundary, which will be off by one cycle. The second is the `comp_level` of the window that starts one cycle after that boundary's pulse. So the error becomes visible within a single divider period. A configuration copied at the wrong time shows up as a period of the wrong length, either the one in progress or the next one. A broken window counter shows up as a `comp_active` edge on the wrong cycle, no more than 129 cycles after a pulse. The bench models every boundary independently. It compares each measured pulse spacing with the model, and it compares the window flag and the amplitude on every cycle.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
   localparam int N_W     = 16;
   localparam int NF_W    = 3;
   localparam int FC_W    = 8;
   localparam int MOD_HI  = 8;
   localparam int MOD_LO  = 5;
   localparam int ACC_W   = $clog2(MOD_HI);
   localparam int MOD_W   = ACC_W + 1;
   localparam int LVL_W   = ACC_W + FC_W;

   typedef struct packed {
      logic [N_W-1:0]  n;
      logic [NF_W-1:0] nf;
      logic            mod5;
      logic [FC_W-1:0] fc;
   } frac_cfg_t;
endpackage

// File: rtl/frac_div_count.sv
module frac_div_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             clr,
   input  logic [CNT_W-1:0] ratio,
   input  logic             stretch,
   output logic             term
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   // last count of the period: ratio-1, one more when stretched
   assign lim  = ratio - CNT_W'(1) + {{(CNT_W-1){1'b0}}, stretch};
   assign term = (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (clr || term) cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum
   import frac_div_pkg::*;
(
   input  logic             clk,
   input  logic             clr,
   input  logic             step,
   input  logic             restart,
   input  logic [NF_W-1:0]  nf,
   input  logic             mod5,
   output logic [ACC_W-1:0] acc_q,
   output logic             carry_q
);
   logic [NF_W-1:0]  nf_eff;
   logic [MOD_W-1:0] qm;
   logic [MOD_W-1:0] sum;
   logic             wrap;

   // in the short modulus an oversized increment is folded back first
   assign nf_eff = (mod5 && (nf >= NF_W'(MOD_LO))) ? nf - NF_W'(MOD_LO) : nf;
   assign qm     = mod5 ? MOD_W'(MOD_LO) : MOD_W'(MOD_HI);
   assign sum    = {1'b0, acc_q} + MOD_W'(nf_eff);
   assign wrap   = (sum >= qm);

   always_ff @(posedge clk) begin
      if (clr || (step && restart)) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
      end else if (step) begin
         acc_q   <= wrap ? ACC_W'(sum - qm) : ACC_W'(sum);
         carry_q <= wrap;
      end
   end
endmodule

// File: rtl/frac_div_comp.sv
module frac_div_comp
   import frac_div_pkg::*;
#(
   parameter int WIN_LEN = 128
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             start,
   input  logic [ACC_W-1:0] frd,
   input  logic [FC_W-1:0]  fc,
   output logic             active,
   output logic [LVL_W-1:0] level
);
   localparam int WC_W = $clog2(WIN_LEN + 1);

   logic [LVL_W-1:0] part [FC_W];
   logic [LVL_W-1:0] run  [FC_W+1];
   logic [WC_W-1:0]  wcnt_q;
   logic [LVL_W-1:0] lvl_q;

   // shift-add product, one partial term per code bit
   assign run[0] = '0;
   for (genvar i = 0; i < FC_W; i++) begin : g_pp
      assign part[i]  = fc[i] ? (LVL_W'(frd) << i) : '0;
      assign run[i+1] = run[i] + part[i];
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         wcnt_q <= '0;
         lvl_q  <= '0;
      end else if (start) begin
         wcnt_q <= WC_W'(WIN_LEN);
         lvl_q  <= run[FC_W];
      end else if (wcnt_q != '0) begin
         wcnt_q <= wcnt_q - WC_W'(1);
      end
   end

   assign active = (wcnt_q != '0);
   assign level  = active ? lvl_q : '0;
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
   import frac_div_pkg::*;
#(
   parameter int N_MIN   = 512,
   parameter int WIN_LEN = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn,
   input  logic [N_W-1:0]   n_ratio,
   input  logic [NF_W-1:0]  nf_inc,
   input  logic             mod5_sel,
   input  logic [FC_W-1:0]  fc_code,
   output logic             div_pulse,
   output logic             comp_active,
   output logic [LVL_W-1:0] comp_level
);
   if (WIN_LEN >= N_MIN) begin : g_bad_win
      $error("window must be shorter than the shortest period");
   end
   if (N_MIN < 2 || N_MIN >= (1 << N_W)) begin : g_bad_nmin
      $error("minimum ratio out of counter range");
   end
   if (NF_W > ACC_W) begin : g_bad_nf
      $error("increment wider than accumulator");
   end

   logic             clr;
   logic             term;
   logic             restart;
   logic             pulse_q;
   logic             carry_q;
   logic             act_mod5;
   logic [ACC_W-1:0] acc_q;
   frac_cfg_t        cfg_in;
   frac_cfg_t        act_cfg;

   assign clr = !rst_n || pwr_dn;

   always_comb begin
      cfg_in.n    = (n_ratio < N_W'(N_MIN)) ? N_W'(N_MIN) : n_ratio;
      cfg_in.nf   = nf_inc;
      cfg_in.mod5 = mod5_sel;
      cfg_in.fc   = fc_code;
   end

   // working configuration follows the inputs only at a period boundary
   always_ff @(posedge clk) begin
      if (clr) begin
         act_cfg <= cfg_in;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= term;
         if (term) act_cfg <= cfg_in;
      end
   end

   assign restart  = (cfg_in.mod5 != act_cfg.mod5);
   assign act_mod5 = act_cfg.mod5;

   frac_div_count #(.CNT_W(N_W)) u_cnt (
      .clk     (clk),
      .clr     (clr),
      .ratio   (act_cfg.n),
      .stretch (carry_q),
      .term    (term)
   );

   frac_div_accum u_acc (
      .clk     (clk),
      .clr     (clr),
      .step    (term),
      .restart (restart),
      .nf      (act_cfg.nf),
      .mod5    (act_cfg.mod5),
      .acc_q   (acc_q),
      .carry_q (carry_q)
   );

   frac_div_comp #(.WIN_LEN(WIN_LEN)) u_comp (
      .clk    (clk),
      .clr    (clr),
      .start  (pulse_q),
      .frd    (acc_q),
      .fc     (act_cfg.fc),
      .active (comp_active),
      .level  (comp_level)
   );

   assign div_pulse = pulse_q;
endmodule

// File: rtl/frac_div_ctrl_chk.sv
module frac_div_ctrl_chk
   import frac_div_pkg::*;
#(
   parameter int N_MIN   = 512,
   parameter int WIN_LEN = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_dn,
   input logic             div_pulse,
   input logic             comp_active,
   input logic [LVL_W-1:0] comp_level,
   input logic [ACC_W-1:0] acc_q,
   input logic             act_mod5
);
   localparam int GAP_W = N_W + 1;
   localparam int RUN_W = $clog2(WIN_LEN + 2);

   logic [GAP_W-1:0] gap_q;
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || pwr_dn) begin
         gap_q <= '0;
         run_q <= '0;
      end else begin
         if (div_pulse)       gap_q <= '0;
         else if (~&gap_q)    gap_q <= gap_q + GAP_W'(1);
         if (comp_active && (~&run_q)) run_q <= run_q + RUN_W'(1);
         else if (!comp_active)        run_q <= '0;
      end
   end

   // R2
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R7
   period_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> (gap_q >= GAP_W'(N_MIN - 1)));

   // R3
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_mod5 |-> (acc_q < ACC_W'(MOD_LO)));

   // R8
   win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_pulse && !pwr_dn && rst_n) |=> comp_active);

   // R8
   win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comp_active |-> (run_q < RUN_W'(WIN_LEN)));

   // R9
   lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_active && $past(comp_active)) |-> $stable(comp_level));
endmodule

bind frac_div_ctrl frac_div_ctrl_chk #(.N_MIN(N_MIN), .WIN_LEN(WIN_LEN)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_dn      (pwr_dn),
   .div_pulse   (div_pulse),
   .comp_active (comp_active),
   .comp_level  (comp_level),
   .acc_q       (acc_q),
   .act_mod5    (act_mod5)
);

// File: tb/frac_div_ctrl_tb_top.sv
`timescale 1ns/1ps
module frac_div_ctrl_tb_top;
   localparam int WIN  = 128;
   localparam int NMIN = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_dn = 1'b0;
   logic [15:0] n_ratio = 16'd600;
   logic [2:0]  nf_inc = 3'd2;
   logic        mod5_sel = 1'b1;
   logic [7:0]  fc_code = 8'd128;
   logic        div_pulse;
   logic        comp_active;
   logic [10:0] comp_level;

   always #2.5 clk = ~clk;

   frac_div_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwr_dn      (pwr_dn),
      .n_ratio     (n_ratio),
      .nf_inc      (nf_inc),
      .mod5_sel    (mod5_sel),
      .fc_code     (fc_code),
      .div_pulse   (div_pulse),
      .comp_active (comp_active),
      .comp_level  (comp_level)
   );

   int    checks = 0;
   int    fails = 0;
   int    m_n, m_nf, m_mod5, m_fc, m_acc, m_extra;
   int    gap, exp_win, exp_lvl, pulses;
   bit    rnd_mode = 0;
   string tag = "R2";

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp_n(input int v);
      return (v < NMIN) ? NMIN : v;
   endfunction

   task automatic capture();
      m_n = clamp_n(int'(n_ratio)); m_nf = int'(nf_inc);
      m_mod5 = int'(mod5_sel); m_fc = int'(fc_code);
   endtask

   task automatic boundary();
      int nfe, q, s;
      nfe = (m_mod5 == 1 && m_nf >= 5) ? m_nf - 5 : m_nf;
      q = (m_mod5 == 1) ? 5 : 8;
      s = m_acc + nfe;
      m_extra = (s >= q) ? 1 : 0;
      m_acc = (s >= q) ? s - q : s;
      if (int'(mod5_sel) != m_mod5) begin
         m_acc = 0; m_extra = 0;
      end
      capture();
      exp_win = WIN;
      exp_lvl = m_acc * m_fc;
   endtask

   task automatic tick();
      @(negedge clk);
      if (!rst_n || pwr_dn) begin
         // R1: outputs cleared while held
         chk(div_pulse == 1'b0 && comp_active == 1'b0, "R1 clear", int'(div_pulse), 0);
      end else begin
         gap++;
         chk(comp_active == (exp_win > 0), "R8 window", int'(comp_active), int'(exp_win > 0));
         chk(int'(comp_level) == ((exp_win > 0) ? exp_lvl : 0), "R9 level",
             int'(comp_level), (exp_win > 0) ? exp_lvl : 0);
         if (exp_win > 0) exp_win--;
         if (div_pulse) begin
            chk(gap == m_n + m_extra, tag, gap, m_n + m_extra);
            gap = 0;
            pulses++;
            boundary();
         end
      end
      if (rnd_mode && ($urandom % 400) == 0) begin
         n_ratio  = 16'(NMIN + ($urandom % 200));
         nf_inc   = 3'($urandom % 8);
         mod5_sel = 1'($urandom % 2);
         fc_code  = 8'($urandom % 256);
      end
   endtask

   task automatic release_clear();
      rst_n = 1'b1; pwr_dn = 1'b0;
      m_acc = 0; m_extra = 0; gap = 0; exp_win = 0;
      capture();
   endtask

   task automatic run_periods(input int k);
      int target;
      target = pulses + k;
      while (pulses < target) tick();
   endtask

   task automatic run_ticks(input int k);
      for (int i = 0; i < k; i++) tick();
   endtask

   initial begin
      void'($urandom(32'd4711));
      // R1: reset state and first period
      for (int i = 0; i < 4; i++) tick();
      release_clear();
      tag = "R1";
      run_periods(1);
      // R3: modulo 5 with increment 2
      tag = "R3";
      run_periods(6);
      // R5: mid-period change only acts after the next pulse
      tag = "R5";
      run_ticks(200);
      n_ratio = 16'd700; nf_inc = 3'd3; fc_code = 8'd80;
      run_periods(3);
      // R6: modulus switch restarts the accumulator
      tag = "R6";
      run_ticks(100);
      mod5_sel = 1'b0;
      run_periods(9);
      // R4: oversized increment folded in modulo 5
      tag = "R4";
      mod5_sel = 1'b1; nf_inc = 3'd7; fc_code = 8'd255; n_ratio = 16'd520;
      run_periods(8);
      // R7: ratio below the minimum
      tag = "R7";
      n_ratio = 16'd100; mod5_sel = 1'b0; nf_inc = 3'd0;
      run_periods(3);
      // R1: power-down in the middle of a window
      tag = "R1";
      n_ratio = 16'd530; nf_inc = 3'd5;
      run_periods(1);
      run_ticks(40);
      pwr_dn = 1'b1;
      run_ticks(3);
      release_clear();
      run_periods(3);
      // R2: random reprogramming
      tag = "R2";
      rnd_mode = 1;
      run_periods(70);
      rnd_mode = 0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000.0 * 5.0);
      checks++; fails++;
      $display("FAIL R2 watchdog actual=timeout expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule